// File: doc/BRIEF.md
# Four-Channel Wiper and Stored-Setting Register Bank

This block holds the digital state behind four potentiometer channels. Each channel owns one volatile 8-bit wiper register, whose value drives that channel's tap decoder, and four 8-bit stored-setting registers. The stored-setting registers stand in for nonvolatile cells. They are ordinary flops, and a parameter fills them at reset. A serial front end decodes bus traffic into single-cycle command strobes. The bank executes each accepted strobe in one clock edge.

The bank supports direct reads and writes of either register kind. It moves data between a stored setting and the wiper of one channel, or of all four channels at once with the same register index. It also steps a wiper's tap up or down by one position. Any command that changes a stored setting models the slow nonvolatile write. The whole bank then reports busy for a parameterised number of clock cycles, and it drops every command that arrives during that time. Reset recalls stored setting 0 of each channel into its wiper.

Top module: `potRegBank`

## Requirements
- R1: While reset is asserted and after it is released, stored setting r of channel c holds byte c*4+r of the DR_INIT parameter (bits (c*4+r)*8+7 down to (c*4+r)*8). Wiper c holds a copy of stored setting 0 of channel c. busy is 0 and rdData is 0.
- R2: Command 2 (cmdOp=2) writes cmdData into the wiper of channel cmdPot. Command 1 reads that wiper: rdData shows the full 8 bits after the clock edge that accepts the read. rdData changes only after an accepted read (command 1 or 3).
- R3: Command 4 writes cmdData into stored setting cmdReg of channel cmdPot. Command 3 reads that setting into rdData one edge later.
- R4: Command 5 copies stored setting cmdReg of channel cmdPot into that channel's wiper. Command 6 copies the wiper of channel cmdPot into its stored setting cmdReg.
- R5: Command 7 copies stored setting cmdReg into the wiper in every channel. Command 8 copies every channel's wiper into its stored setting cmdReg. For both commands cmdPot is ignored.
- R6: Command 9 adds one to tap bits 5:0 of the wiper of channel cmdPot, and command 10 subtracts one. The tap saturates at 63 and at 0. Bits 7 (cascade) and 6 (wiper disable) are left unchanged.
- R7: Commands 4, 6 and 8 raise busy on the edge that accepts them. busy then stays high for exactly BUSY_CYCLES cycles. Commands 2, 5, 7, 9 and 10 never raise busy.
- R8: A command presented while busy is 1 is dropped, including one presented in the last busy cycle. The wipers, the stored settings and rdData are left unchanged.
- R9: wiperBus carries wiper c on bits c*8+7 to c*8. Within each byte, bit 7 is the cascade flag, bit 6 is the wiper-disable flag and bits 5:0 are the tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset and power-up recall |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 4 | Command code (0 no-op, 1 to 10 as listed in the requirements) |
| cmdPot | input | 2 | Channel select |
| cmdReg | input | 2 | Stored-setting select |
| cmdData | input | 8 | Write data |
| rdData | output | 8 | Read result, held until the next accepted read |
| busy | output | 1 | High while a modelled nonvolatile write is in progress |
| wiperBus | output | 32 | All four wiper registers, for the tap decoders |

## Verification
The case that needs care is the edge where the busy counter expires while a new command is presented at the same time. A command in the last busy cycle must be dropped, and the same command one cycle later must take effect. The bench counts busy cycles from the accepting edge and, on the last one, drives a wiper write. It then checks that the wiper is unchanged and busy is low, repeats the write, and checks that it lands. Reads and writes aimed at other registers are also issued during the busy window. The bench then checks that rdData and the wipers kept their values.

// File: rtl/potbank_pkg.sv
package potbank_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_RD_WCR  = 4'd1,
    OP_WR_WCR  = 4'd2,
    OP_RD_DR   = 4'd3,
    OP_WR_DR   = 4'd4,
    OP_LD_WCR  = 4'd5,
    OP_ST_DR   = 4'd6,
    OP_GLD_WCR = 4'd7,
    OP_GST_DR  = 4'd8,
    OP_INC     = 4'd9,
    OP_DEC     = 4'd10
  } potOp_t;

  // strobes from control to datapath, at most one action bit set per cycle
  typedef struct packed {
    logic rdWcr;
    logic wrWcr;
    logic rdDr;
    logic wrDr;
    logic ldWcr;
    logic stDr;
    logic allPots;
    logic stepUp;
    logic stepDn;
  } bankStb_t;

endpackage

// File: rtl/potbank_ctrl.sv
module potbank_ctrl
  import potbank_pkg::*;
#(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [3:0] cmdOp,
  output bankStb_t   stb,
  output logic       busy
);

  localparam int CNTW = $clog2(BUSY_CYCLES + 1);

  logic [CNTW-1:0] busyCnt;
  logic            accept;
  logic            nvOp;
  potOp_t          op;

  assign op     = potOp_t'(cmdOp);
  assign accept = cmdValid && (busyCnt == '0);
  assign nvOp   = (op == OP_WR_DR) || (op == OP_ST_DR) || (op == OP_GST_DR);
  assign busy   = (busyCnt != '0);

  always_comb begin
    stb         = '0;
    stb.rdWcr   = accept && (op == OP_RD_WCR);
    stb.wrWcr   = accept && (op == OP_WR_WCR);
    stb.rdDr    = accept && (op == OP_RD_DR);
    stb.wrDr    = accept && (op == OP_WR_DR);
    stb.ldWcr   = accept && ((op == OP_LD_WCR) || (op == OP_GLD_WCR));
    stb.stDr    = accept && ((op == OP_ST_DR) || (op == OP_GST_DR));
    stb.allPots = accept && ((op == OP_GLD_WCR) || (op == OP_GST_DR));
    stb.stepUp  = accept && (op == OP_INC);
    stb.stepDn  = accept && (op == OP_DEC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (accept && nvOp) begin
      busyCnt <= CNTW'(BUSY_CYCLES);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - CNTW'(1);
    end
  end

endmodule

// File: rtl/potbank_dp.sv
module potbank_dp
  import potbank_pkg::*;
#(
  parameter int NPOT    = 4,
  parameter int NREG    = 4,
  parameter int WIDTH   = 8,
  parameter int TAPBITS = 6,
  parameter logic [NPOT*NREG*WIDTH-1:0] DR_INIT = '0,
  localparam int PB = $clog2(NPOT),
  localparam int RB = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bankStb_t              stb,
  input  logic [PB-1:0]         pot,
  input  logic [RB-1:0]         sel,
  input  logic [WIDTH-1:0]      data,
  output logic [WIDTH-1:0]      rdData,
  output logic [NPOT*WIDTH-1:0] wiperBus
);

  logic [NPOT*NREG*WIDTH-1:0] drBus;

  for (genvar c = 0; c < NPOT; c++) begin : g_chan
    logic [WIDTH-1:0]   wcrR;
    logic [WIDTH-1:0]   drR [NREG];
    logic [TAPBITS-1:0] tap;
    logic               selMe;
    logic               hit;

    assign tap   = wcrR[TAPBITS-1:0];
    assign selMe = (pot == PB'(c));
    assign hit   = selMe || stb.allPots;
    assign wiperBus[c*WIDTH +: WIDTH] = wcrR;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wcrR <= DR_INIT[(c*NREG)*WIDTH +: WIDTH];
      end else if (stb.wrWcr && selMe) begin
        wcrR <= data;
      end else if (stb.ldWcr && hit) begin
        wcrR <= drR[sel];
      end else if (stb.stepUp && selMe && (tap != '1)) begin
        wcrR[TAPBITS-1:0] <= tap + TAPBITS'(1);
      end else if (stb.stepDn && selMe && (tap != '0)) begin
        wcrR[TAPBITS-1:0] <= tap - TAPBITS'(1);
      end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
      assign drBus[(c*NREG+r)*WIDTH +: WIDTH] = drR[r];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          drR[r] <= DR_INIT[(c*NREG+r)*WIDTH +: WIDTH];
        end else if (stb.wrDr && selMe && (sel == RB'(r))) begin
          drR[r] <= data;
        end else if (stb.stDr && hit && (sel == RB'(r))) begin
          drR[r] <= wcrR;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdWcr) begin
      rdData <= wiperBus[int'(pot)*WIDTH +: WIDTH];
    end else if (stb.rdDr) begin
      rdData <= drBus[(int'(pot)*NREG + int'(sel))*WIDTH +: WIDTH];
    end
  end

endmodule

// File: rtl/potRegBank.sv
module potRegBank
  import potbank_pkg::*;
#(
  parameter int NPOT        = 4,
  parameter int NREG        = 4,
  parameter int WIDTH       = 8,
  parameter int TAPBITS     = 6,
  parameter int BUSY_CYCLES = 500000,
  parameter logic [NPOT*NREG*WIDTH-1:0] DR_INIT =
    128'h33323130_23222120_13121110_03020100
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  input  logic [3:0]                 cmdOp,
  input  logic [$clog2(NPOT)-1:0]    cmdPot,
  input  logic [$clog2(NREG)-1:0]    cmdReg,
  input  logic [WIDTH-1:0]           cmdData,
  output logic [WIDTH-1:0]           rdData,
  output logic                       busy,
  output logic [NPOT*WIDTH-1:0]      wiperBus
);

  bankStb_t stb;

  potbank_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .stb      (stb),
    .busy     (busy)
  );

  potbank_dp #(
    .NPOT    (NPOT),
    .NREG    (NREG),
    .WIDTH   (WIDTH),
    .TAPBITS (TAPBITS),
    .DR_INIT (DR_INIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .pot      (cmdPot),
    .sel      (cmdReg),
    .data     (cmdData),
    .rdData   (rdData),
    .wiperBus (wiperBus)
  );

endmodule

// File: rtl/potbank_chk.sv
module potbank_chk
  import potbank_pkg::*;
#(
  parameter int NPOT    = 4,
  parameter int WIDTH   = 8,
  parameter int TAPBITS = 6,
  localparam int PB = $clog2(NPOT)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cmdValid,
  input logic [3:0]            cmdOp,
  input logic [PB-1:0]         cmdPot,
  input logic [WIDTH-1:0]      rdData,
  input logic                  busy,
  input logic [NPOT*WIDTH-1:0] wiperBus
);

  logic [TAPBITS-1:0] selTap;
  logic [TAPBITS-1:0] tapAtLast;
  logic [TAPBITS-1:0] lastTapNext;
  logic [PB-1:0]      lastPot;
  logic               take;

  assign take      = cmdValid && !busy;
  assign selTap    = wiperBus[int'(cmdPot)*WIDTH +: TAPBITS];
  assign tapAtLast = wiperBus[int'(lastPot)*WIDTH +: TAPBITS];

  always_ff @(posedge clk) begin
    lastPot     <= cmdPot;
    lastTapNext <= selTap + TAPBITS'(1);
  end

  p_drop_while_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && busy) |=> ($stable(wiperBus) && $stable(rdData)));

  p_nv_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (take && (cmdOp == OP_WR_DR || cmdOp == OP_ST_DR || cmdOp == OP_GST_DR)) |=> busy);

  p_volatile_nobusy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (take && (cmdOp == OP_WR_WCR || cmdOp == OP_LD_WCR || cmdOp == OP_GLD_WCR ||
              cmdOp == OP_INC || cmdOp == OP_DEC)) |=> !busy);

  p_step_up_r6: assert property (@(posedge clk) disable iff (!rstN)
    (take && cmdOp == OP_INC && selTap != '1) |=> (tapAtLast == lastTapNext));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(take && (cmdOp == OP_RD_WCR || cmdOp == OP_RD_DR)) |=> $stable(rdData));

endmodule

bind potRegBank potbank_chk #(
  .NPOT    (NPOT),
  .WIDTH   (WIDTH),
  .TAPBITS (TAPBITS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdPot   (cmdPot),
  .rdData   (rdData),
  .busy     (busy),
  .wiperBus (wiperBus)
);

// File: tb/sim_potRegBank.sv
`timescale 1ns/1ps
module sim_potRegBank;

  localparam int BUSY = 12;
  localparam int NV   = 21;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmdOp = 4'd0;
  logic [1:0]  cmdPot = 2'd0;
  logic [1:0]  cmdReg = 2'd0;
  logic [7:0]  cmdData = 8'd0;
  logic [7:0]  rdData;
  logic        busy;
  logic [31:0] wiperBus;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  potRegBank #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPot(cmdPot), .cmdReg(cmdReg), .cmdData(cmdData),
    .rdData(rdData), .busy(busy), .wiperBus(wiperBus)
  );

  // {req[4], op[4], pot[2], reg[2], data[8], chk[2], exp[8]}
  // chk: 0 none, 1 rdData, 2 wiper of pot
  localparam logic [29:0] VEC [NV] = '{
    {4'd1, 4'd1,  2'd1, 2'd0, 8'h00, 2'd1, 8'h10}, // R1 recall of DR0
    {4'd1, 4'd1,  2'd3, 2'd0, 8'h00, 2'd1, 8'h30}, // R1
    {4'd2, 4'd2,  2'd2, 2'd0, 8'h3F, 2'd2, 8'h3F}, // R2 write wiper
    {4'd6, 4'd9,  2'd2, 2'd0, 8'h00, 2'd2, 8'h3F}, // R6 saturate high
    {4'd6, 4'd10, 2'd0, 2'd0, 8'h00, 2'd2, 8'h00}, // R6 saturate low
    {4'd6, 4'd9,  2'd0, 2'd0, 8'h00, 2'd2, 8'h01}, // R6 step up
    {4'd3, 4'd4,  2'd1, 2'd2, 8'h5A, 2'd0, 8'h00}, // R3 write setting
    {4'd3, 4'd3,  2'd1, 2'd2, 8'h00, 2'd1, 8'h5A}, // R3 read back
    {4'd3, 4'd3,  2'd3, 2'd1, 8'h00, 2'd1, 8'h31}, // R3 preload value
    {4'd4, 4'd5,  2'd3, 2'd1, 8'h00, 2'd2, 8'h31}, // R4 setting to wiper
    {4'd4, 4'd6,  2'd2, 2'd3, 8'h00, 2'd0, 8'h00}, // R4 wiper to setting
    {4'd4, 4'd3,  2'd2, 2'd3, 8'h00, 2'd1, 8'h3F}, // R4
    {4'd5, 4'd7,  2'd1, 2'd2, 8'h00, 2'd2, 8'h5A}, // R5 global load
    {4'd5, 4'd0,  2'd0, 2'd0, 8'h00, 2'd2, 8'h02}, // R5
    {4'd5, 4'd0,  2'd3, 2'd0, 8'h00, 2'd2, 8'h32}, // R5
    {4'd9, 4'd2,  2'd0, 2'd0, 8'hC5, 2'd2, 8'hC5}, // R9 flag bits on bus
    {4'd6, 4'd9,  2'd0, 2'd0, 8'h00, 2'd2, 8'hC6}, // R6 flags kept
    {4'd5, 4'd8,  2'd2, 2'd0, 8'h00, 2'd0, 8'h00}, // R5 global store
    {4'd5, 4'd3,  2'd0, 2'd0, 8'h00, 2'd1, 8'hC6}, // R5
    {4'd5, 4'd3,  2'd3, 2'd0, 8'h00, 2'd1, 8'h32}, // R5
    {4'd2, 4'd1,  2'd2, 2'd0, 8'h00, 2'd1, 8'h22}  // R2 read wiper
  };

  function automatic string reqName(logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] op, logic [1:0] p, logic [1:0] r, logic [7:0] d);
    cmdValid = 1'b1; cmdOp = op; cmdPot = p; cmdReg = r; cmdData = d;
  endtask

  task automatic issue(logic [3:0] op, logic [1:0] p, logic [1:0] r, logic [7:0] d);
    while (busy) @(negedge clk);
    drive(op, p, r, d);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    int busyN;
    repeat (3) @(negedge clk);
    // R1 and R9: reset state and wiper bus layout
    check("R1", {31'd0, busy}, 32'd0);
    check("R1", {24'd0, rdData}, 32'd0);
    check("R9", wiperBus, 32'h30201000);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      issue(v[25:22], v[21:20], v[19:18], v[17:10]);
      if (v[9:8] == 2'd1)
        check(reqName(v[29:26]), {24'd0, rdData}, {24'd0, v[7:0]});
      else if (v[9:8] == 2'd2)
        check(reqName(v[29:26]), {24'd0, wiperBus[v[21:20]*8 +: 8]}, {24'd0, v[7:0]});
    end

    // R7 and R8: busy length, drops inside the window and on its last cycle
    while (busy) @(negedge clk);
    issue(4'd4, 2'd0, 2'd1, 8'h77);
    busyN = 0;
    while (busy) begin
      busyN++;
      if (busyN == 2)         drive(4'd2, 2'd1, 2'd0, 8'h00);
      else if (busyN == 3)    drive(4'd3, 2'd1, 2'd2, 8'h00);
      else if (busyN == BUSY) drive(4'd2, 2'd1, 2'd0, 8'h11);
      else                    cmdValid = 1'b0;
      @(negedge clk);
    end
    cmdValid = 1'b0;
    check("R7", busyN, BUSY);
    check("R8", {24'd0, wiperBus[15:8]}, 32'h5A);
    check("R8", {24'd0, rdData}, 32'h22);
    issue(4'd2, 2'd1, 2'd0, 8'h11);
    check("R8", {24'd0, wiperBus[15:8]}, 32'h11);
    check("R7", {31'd0, busy}, 32'd0);
    issue(4'd3, 2'd0, 2'd1, 8'h00);
    check("R3", {24'd0, rdData}, 32'h77);
    issue(4'd5, 2'd0, 2'd1, 8'h00);
    check("R7", {31'd0, busy}, 32'd0);
    check("R4", {24'd0, wiperBus[7:0]}, 32'h77);

    // R2: read result holds across other commands
    issue(4'd1, 2'd1, 2'd0, 8'h00);
    check("R2", {24'd0, rdData}, 32'h11);
    issue(4'd2, 2'd1, 2'd0, 8'h22);
    issue(4'd10, 2'd1, 2'd0, 8'h00);
    check("R2", {24'd0, rdData}, 32'h11);
    check("R6", {24'd0, wiperBus[15:8]}, 32'h21);

    // R1: second reset reloads preload and recalls setting 0
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1", wiperBus, 32'h30201000);
    check("R1", {24'd0, rdData}, 32'd0);
    issue(4'd3, 2'd1, 2'd2, 8'h00);
    check("R1", {24'd0, rdData}, 32'h12);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule